// File: doc/BRIEF.md
# Translation-Table Base Control Register Bank

This block is a system register bank for a processor core. It holds the two translation-table base registers and the table-base control word that a page-table walker reads. Software reaches the bank through a small register-access port. An access has a strobe, a read/write flag, a 3-bit selector and 32-bit data. Read data is combinational from the addressed slot, so a read completes in the same cycle as its strobe.

Writing the control word does more than store it. The same write also recomputes two address masks from the 3-bit field N, and the walker uses those masks directly:
- The table-select mask has the top N bits set.
- The base-alignment mask clears the low (14 - N) bits.

A static mode input switches the bank into protection-unit mode. In that mode selectors 0 and 1 reach a data-cache configuration word and an instruction-cache configuration word. These are held in storage of their own. An access to a selector that the current mode does not define raises a one-cycle error flag and changes nothing.

Top module: `ttb_ctrl_bank`

## Requirements
- R1: After reset, every register reads 0, the table-select mask is 0x00000000, the base-alignment mask is 0xFFFFC000 and the error flag is low.
- R2: In translation mode (`prot_mode`=0), selector 0 and selector 1 are two independent 32-bit read/write registers. Writing selector 1 never changes the value read at selector 0, and writing selector 0 never changes the value read at selector 1.
- R3: In translation mode, selector 2 is the control word. A write keeps only data bits [2:0] as N. A read returns N in bits [2:0] and zero in bits [31:3].
- R4: One cycle after a control write, `tsel_mask` equals the inverse of 0xFFFFFFFF logically shifted right by N. It is 0 for N=0 and 0xFE000000 for N=7.
- R5: One cycle after a control write, `align_mask` equals the inverse of 0x00003FFF logically shifted right by N. It is 0xFFFFC000 for N=0 and 0xFFFFFF80 for N=7.
- R6: Both masks change only on a control write. Register writes, reads, idle cycles and undefined accesses leave them unchanged.
- R7: In protection mode (`prot_mode`=1), selector 0 is the data-cache configuration register and selector 1 is the instruction-cache configuration register. Both are plain 32-bit read/write registers.
- R8: In translation mode, selectors 3 to 7 are undefined. An access to one of them asserts `acc_undef` in the same cycle, reads 0, and changes no register and no mask.
- R9: In protection mode, selectors 2 to 7 are undefined, with the same effect as in R8. A write to selector 2 in this mode leaves the control word and both masks untouched.
- R10: The two modes use separate storage. Writes made in one mode do not change any value read back in the other mode.
- R11: `acc_undef` is low in every cycle where `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_mode | input | 1 | 0 = translation mode, 1 = protection-unit mode |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register selector |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the addressed register, 0 when undefined |
| acc_undef | output | 1 | Undefined-selector pulse for the current access |
| tsel_mask | output | 32 | Table-select mask |
| align_mask | output | 32 | Base-alignment mask |

## Verification
The assertions check the following on every cycle:
- the error flag follows the strobe and the per-mode selector range;
- the control word reads back with its upper bits clear;
- both masks hold still unless a translation-mode control write occurred;
- the mask values match the N that was written in the cycle before.

Other behaviours need the bench's scenarios, which compare every read against a behavioural model:
- the independence of the two table-base registers;
- the separation of storage between the modes;
- undefined writes leaving the stored words untouched.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    localparam int DATA_W     = 32;
    localparam int SEL_W      = 3;
    localparam int CTRL_W     = 3;
    localparam int ALIGN_BITS = 14;

    typedef enum logic [2:0] {
        SLOT_NONE  = 3'd0,
        SLOT_BASE0 = 3'd1,
        SLOT_BASE1 = 3'd2,
        SLOT_CTRL  = 3'd3,
        SLOT_DCFG  = 3'd4,
        SLOT_ICFG  = 3'd5
    } slot_e;

    typedef struct packed {
        logic [DATA_W-1:0] base0;
        logic [DATA_W-1:0] base1;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] tsel;
        logic [DATA_W-1:0] align;
        logic [DATA_W-1:0] dcfg;
        logic [DATA_W-1:0] icfg;
    } bank_t;
endpackage

// File: rtl/ttb_sel_decode.sv
module ttb_sel_decode
    import ttb_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          prot_mode_i,
    input  logic [SW-1:0] sel_i,
    output slot_e         slot_o
);
    localparam logic [SW-1:0] SEL_0 = SW'(0);
    localparam logic [SW-1:0] SEL_1 = SW'(1);
    localparam logic [SW-1:0] SEL_2 = SW'(2);

    always_comb begin
        slot_o = SLOT_NONE;
        if (prot_mode_i) begin
            if (sel_i == SEL_0)      slot_o = SLOT_DCFG;
            else if (sel_i == SEL_1) slot_o = SLOT_ICFG;
        end else begin
            if (sel_i == SEL_0)      slot_o = SLOT_BASE0;
            else if (sel_i == SEL_1) slot_o = SLOT_BASE1;
            else if (sel_i == SEL_2) slot_o = SLOT_CTRL;
        end
    end
endmodule

// File: rtl/ttb_mask_calc.sv
module ttb_mask_calc #(
    parameter int DW = 32,
    parameter int CW = 3,
    parameter int AB = 14
) (
    input  logic [CW-1:0] n_i,
    output logic [DW-1:0] tsel_o,
    output logic [DW-1:0] align_o
);
    // bit g of inverse(all-ones >> n) is set when g + n reaches DW;
    // bit g of inverse(low-AB-ones >> n) is set when g + n reaches AB
    generate
        for (genvar g = 0; g < DW; g++) begin : g_bit
            assign tsel_o[g]  = (32'(n_i) + 32'(g)) >= 32'(DW);
            assign align_o[g] = (32'(n_i) + 32'(g)) >= 32'(AB);
        end
    endgenerate
endmodule

// File: rtl/ttb_ctrl_bank.sv
module ttb_ctrl_bank
    import ttb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_undef,
    output logic [DATA_W-1:0] tsel_mask,
    output logic [DATA_W-1:0] align_mask
);
    localparam logic [DATA_W-1:0] ALIGN_RST = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

    bank_t st_q, st_d;
    slot_e slot;
    logic [DATA_W-1:0] tsel_new, align_new;
    logic wr_en;

    ttb_sel_decode #(.SW(SEL_W)) u_dec (
        .prot_mode_i (prot_mode),
        .sel_i       (acc_sel),
        .slot_o      (slot)
    );

    ttb_mask_calc #(.DW(DATA_W), .CW(CTRL_W), .AB(ALIGN_BITS)) u_mask (
        .n_i     (acc_wdata[CTRL_W-1:0]),
        .tsel_o  (tsel_new),
        .align_o (align_new)
    );

    assign wr_en = acc_valid && acc_write && (slot != SLOT_NONE);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (slot)
                SLOT_BASE0: st_d.base0 = acc_wdata;
                SLOT_BASE1: st_d.base1 = acc_wdata;
                SLOT_CTRL: begin
                    st_d.ctrl  = acc_wdata[CTRL_W-1:0];
                    st_d.tsel  = tsel_new;
                    st_d.align = align_new;
                end
                SLOT_DCFG:  st_d.dcfg = acc_wdata;
                SLOT_ICFG:  st_d.icfg = acc_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base0 <= '0;
            st_q.base1 <= '0;
            st_q.ctrl  <= '0;
            st_q.tsel  <= '0;
            st_q.align <= ALIGN_RST;
            st_q.dcfg  <= '0;
            st_q.icfg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (slot)
            SLOT_BASE0: acc_rdata = st_q.base0;
            SLOT_BASE1: acc_rdata = st_q.base1;
            SLOT_CTRL:  acc_rdata = {{(DATA_W-CTRL_W){1'b0}}, st_q.ctrl};
            SLOT_DCFG:  acc_rdata = st_q.dcfg;
            SLOT_ICFG:  acc_rdata = st_q.icfg;
            default:    acc_rdata = '0;
        endcase
    end

    assign acc_undef  = acc_valid && (slot == SLOT_NONE);
    assign tsel_mask  = st_q.tsel;
    assign align_mask = st_q.align;
endmodule

// File: rtl/ttb_ctrl_bank_chk.sv
module ttb_ctrl_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        prot_mode,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [2:0]  acc_sel,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        acc_undef,
    input logic [31:0] tsel_mask,
    input logic [31:0] align_mask
);
    logic ctrl_wr;
    assign ctrl_wr = acc_valid && acc_write && !prot_mode && (acc_sel == 3'd2);

    // R11
    undef_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_undef);

    // R8
    vm_high_sel_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !prot_mode && acc_sel > 3'd2) |-> (acc_undef && acc_rdata == 32'd0));

    // R9
    pm_high_sel_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && prot_mode && acc_sel > 3'd1) |-> (acc_undef && acc_rdata == 32'd0));

    // R3
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !prot_mode && acc_sel == 3'd2) |-> (acc_rdata[31:3] == 29'd0));

    // R6
    masks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> ($stable(tsel_mask) && $stable(align_mask)));

    // R4
    tsel_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (tsel_mask == ~(32'hFFFF_FFFF >> $past(acc_wdata[2:0]))));

    // R5
    align_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (align_mask == ~(32'h0000_3FFF >> $past(acc_wdata[2:0]))));
endmodule

bind ttb_ctrl_bank ttb_ctrl_bank_chk u_chk (.*);

// File: tb/sim_ttb_ctrl_bank.sv
module sim_ttb_ctrl_bank;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_sel = 3'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic [31:0] acc_rdata;
    logic        acc_undef;
    logic [31:0] tsel_mask;
    logic [31:0] align_mask;

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [31:0] m_b0 = 0, m_b1 = 0, m_d = 0, m_i = 0;
    int          m_n = 0;

    always #(PERIOD/2) clk = ~clk;

    ttb_ctrl_bank u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_undef(input bit pm, input int sel);
        return pm ? (sel > 1) : (sel > 2);
    endfunction

    function automatic logic [31:0] m_read(input bit pm, input int sel);
        if (pm) begin
            if (sel == 0) return m_d;
            if (sel == 1) return m_i;
            return 0;
        end
        if (sel == 0) return m_b0;
        if (sel == 1) return m_b1;
        if (sel == 2) return 32'(m_n);
        return 0;
    endfunction

    function automatic string rd_tag(input bit pm, input int sel);
        if (m_undef(pm, sel)) return pm ? "R9" : "R8";
        if (pm) return "R7";
        return (sel == 2) ? "R3" : "R2";
    endfunction

    // one cycle: drive, compare every output, then apply to the model
    task automatic step(input bit v, input bit w, input bit pm, input int sel, input logic [31:0] d);
        @(negedge clk);
        acc_valid = v; acc_write = w; prot_mode = pm; acc_sel = 3'(sel); acc_wdata = d;
        #1;
        chk("R4", tsel_mask, ~(32'hFFFF_FFFF >> m_n));
        chk("R5", align_mask, ~(32'h0000_3FFF >> m_n));
        if (v) begin
            chk(rd_tag(pm, sel), acc_rdata, m_read(pm, sel));
            chk(pm ? "R9" : "R8", 32'(acc_undef), 32'(m_undef(pm, sel)));
        end else begin
            chk("R11", 32'(acc_undef), 32'd0);
        end
        @(posedge clk);
        #1;
        if (v && w && !m_undef(pm, sel)) begin
            if (pm) begin
                if (sel == 0) m_d = d; else m_i = d;
            end else begin
                if (sel == 0) m_b0 = d;
                else if (sel == 1) m_b1 = d;
                else m_n = int'(d[2:0]);
            end
        end
    endtask

    task automatic rd_expect(input string req, input bit pm, input int sel, input logic [31:0] exp);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; prot_mode = pm; acc_sel = 3'(sel); acc_wdata = 0;
        #1;
        chk(req, acc_rdata, exp);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset values
        chk("R1", tsel_mask, 32'h0000_0000);
        chk("R1", align_mask, 32'hFFFF_C000);
        chk("R1", 32'(acc_undef), 32'd0);
        for (int s = 0; s < 3; s++) rd_expect("R1", 0, s, 32'd0);
        for (int s = 0; s < 2; s++) rd_expect("R1", 1, s, 32'd0);

        // R2 independent table-base registers
        step(1, 1, 0, 0, 32'hA5A5_1234);
        step(1, 1, 0, 1, 32'h5A5A_8765);
        rd_expect("R2", 0, 0, 32'hA5A5_1234);
        rd_expect("R2", 0, 1, 32'h5A5A_8765);
        step(1, 1, 0, 0, 32'h0BAD_F00D);
        rd_expect("R2", 0, 1, 32'h5A5A_8765);

        // R3/R4/R5 every N with garbage upper bits
        for (int n = 0; n < 8; n++) begin
            step(1, 1, 0, 2, 32'hFFFF_FFF8 | 32'(n));
            rd_expect("R3", 0, 2, 32'(n));
            chk("R4", tsel_mask, ~(32'hFFFF_FFFF >> n));
            chk("R5", align_mask, ~(32'h0000_3FFF >> n));
        end
        chk("R4", tsel_mask, 32'hFE00_0000);
        chk("R5", align_mask, 32'hFFFF_FF80);

        // R6 masks untouched by other traffic
        step(1, 1, 0, 0, 32'h1111_1111);
        step(0, 1, 0, 2, 32'h0000_0000);
        step(1, 1, 0, 5, 32'h0000_0002);
        chk("R6", tsel_mask, 32'hFE00_0000);
        chk("R6", align_mask, 32'hFFFF_FF80);

        // R8 undefined selectors in translation mode
        for (int s = 3; s < 8; s++) step(1, 1, 0, s, 32'hDEAD_BEEF);
        rd_expect("R8", 0, 0, 32'h1111_1111);
        rd_expect("R8", 0, 1, 32'h5A5A_8765);

        // R7 cache configuration words
        step(1, 1, 1, 0, 32'hCAFE_0001);
        step(1, 1, 1, 1, 32'hCAFE_0002);
        rd_expect("R7", 1, 0, 32'hCAFE_0001);
        rd_expect("R7", 1, 1, 32'hCAFE_0002);

        // R9 selector 2 and above undefined in protection mode
        for (int s = 2; s < 8; s++) step(1, 1, 1, s, 32'h0000_0003);
        rd_expect("R9", 0, 2, 32'd7);
        chk("R9", tsel_mask, 32'hFE00_0000);
        chk("R9", align_mask, 32'hFFFF_FF80);

        // R10 separate storage across modes
        rd_expect("R10", 0, 0, 32'h1111_1111);
        rd_expect("R10", 0, 1, 32'h5A5A_8765);
        step(1, 1, 0, 0, 32'h7777_7777);
        rd_expect("R10", 1, 0, 32'hCAFE_0001);
        rd_expect("R10", 1, 1, 32'hCAFE_0002);

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), $urandom);
        end

        @(negedge clk);
        acc_valid = 0;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule